// File: doc/BRIEF.md
# Trigger Bus Front-End Synchronizer

This block keeps a set of front-end digitizer boards in step with a central trigger unit. When the trigger unit accepts a request, it drives a one-cycle strobe onto a shared bus. The strobe carries a trigger type code and the low bits of a running event counter, and every front-end receiver sees it in the same cycle. Each receiver stores the type and event bits in a small multi-event buffer. A receiver raises its busy line only when that buffer is full. The OR of all busy lines holds back any further trigger.

The trigger unit can also add a delayed trigger after a prompt one. The delay is set by a cycle count input and the delayed trigger takes its own type code, so the feature needs no change to the logic. On the readout side, an event-builder stage pops one event from every receiver at once. It compares the event bits that each board recorded and, on any disagreement, raises a sticky synchronization error together with the index of the offending board. A per-board drop input models a board that missed a strobe, so that loss of step can be caused on purpose.

Top module: `trig_sync_bus`

## Requirements
- R1: An accepted trigger request drives `bus_strobe` high for exactly one cycle, starting the cycle after the request is sampled. In that cycle `bus_type` equals the requested type and `bus_evt` equals the current event counter.
- R2: The event counter resets to 0, advances by one on every issued strobe (prompt or delayed), and wraps modulo 2^EVT_W.
- R3: `busy_or` is high exactly when at least one board holds DEPTH events. No strobe is issued in a cycle that follows a cycle with `busy_or` high. No strobe is issued in the cycle right after another strobe.
- R4: A request that arrives while issuing is blocked is dropped, not queued.
- R5: If `dly_en` is high when a prompt trigger is accepted, a second strobe follows `dly_cycles` cycles after the prompt one (values below 2 act as 2). That strobe has type `dly_type` and the next event number. Prompt requests are ignored while the delayed trigger is pending.
- R6: A pending delayed trigger that reaches its time while issuing is blocked waits. It is issued on the first edge at which issuing is allowed again.
- R7: Board i stores the bus entry on the edge that ends a strobe cycle, unless `fe_drop[i]` is high in that cycle. `evb_ready` is high when every board holds at least one event. An `evb_pop` with `evb_ready` low has no effect.
- R8: A pop taken while `evb_ready` is high removes the oldest event from every board. One cycle later it gives a one-cycle `evb_valid` with `evb_lsb` and `evb_type` taken from board 0's oldest entry.
- R9: On a taken pop, if some board's oldest event bits differ from board 0's, `sync_err` rises one cycle later. `err_idx` then holds the lowest index of such a board.
- R10: `sync_err` and `err_idx` stay unchanged through later pops until `err_clr`, which clears `sync_err` on the next edge. A clear wins over a mismatch seen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_req | input | 1 | Request for a prompt trigger |
| trig_type | input | TYPE_W | Type code for a prompt trigger |
| dly_en | input | 1 | Arm a delayed trigger behind the next prompt trigger |
| dly_cycles | input | DLY_W | Delay from prompt strobe to delayed strobe, in cycles |
| dly_type | input | TYPE_W | Type code for the delayed trigger |
| fe_drop | input | N_FE | Per-board strobe loss, for fault injection |
| evb_pop | input | 1 | Event builder takes one event from all boards |
| err_clr | input | 1 | Clear the synchronization error |
| bus_strobe | output | 1 | Trigger strobe shared by all boards |
| bus_type | output | TYPE_W | Trigger type on the bus |
| bus_evt | output | EVT_W | Event number low bits on the bus |
| busy_or | output | 1 | OR of all board busy lines |
| fe_busy | output | N_FE | Per-board buffer-full lines |
| evb_ready | output | 1 | Every board holds an event |
| evb_valid | output | 1 | Popped event presented |
| evb_type | output | TYPE_W | Type of the popped event (board 0) |
| evb_lsb | output | EVT_W | Event bits of the popped event (board 0) |
| sync_err | output | 1 | Sticky event-number mismatch flag |
| err_idx | output | $clog2(N_FE) | First mismatching board index |

## Verification
The bench uses the defaults: four boards, a 3-bit type, 4 event bits, buffer depth 2 and a 6-bit delay. With depth 2, two back-to-back triggers fill a buffer and bring the busy gate into play. With 4 event bits, twenty triggers carry the counter through its wrap. With four boards, two separate strobe drops can push different boards out of step, so both the first-index capture and its stickiness are reached.

// File: rtl/trig_sync_bus.sv
module trig_sync_bus #(
  parameter int N_FE   = 4,
  parameter int TYPE_W = 3,
  parameter int EVT_W  = 4,
  parameter int DEPTH  = 2,
  parameter int DLY_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_req,
  input  logic [TYPE_W-1:0]          trig_type,
  input  logic                       dly_en,
  input  logic [DLY_W-1:0]           dly_cycles,
  input  logic [TYPE_W-1:0]          dly_type,
  input  logic [N_FE-1:0]            fe_drop,
  input  logic                       evb_pop,
  input  logic                       err_clr,
  output logic                       bus_strobe,
  output logic [TYPE_W-1:0]          bus_type,
  output logic [EVT_W-1:0]           bus_evt,
  output logic                       busy_or,
  output logic [N_FE-1:0]            fe_busy,
  output logic                       evb_ready,
  output logic                       evb_valid,
  output logic [TYPE_W-1:0]          evb_type,
  output logic [EVT_W-1:0]           evb_lsb,
  output logic                       sync_err,
  output logic [$clog2(N_FE)-1:0]    err_idx
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(N_FE);

  logic [EVT_W-1:0] evt_cnt;
  logic             pend;
  logic [DLY_W-1:0] dcnt;

  wire can_issue = !busy_or && !bus_strobe;
  wire fire_dly  = pend && (dcnt <= DLY_W'(1)) && can_issue;
  wire fire_pr   = !pend && trig_req && can_issue;
  wire fire      = fire_dly || fire_pr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_strobe <= 1'b0;
      bus_type   <= '0;
      bus_evt    <= '0;
      evt_cnt    <= '0;
      pend       <= 1'b0;
      dcnt       <= '0;
    end else begin
      bus_strobe <= fire;
      if (fire) begin
        bus_type <= fire_dly ? dly_type : trig_type;
        bus_evt  <= evt_cnt;
        evt_cnt  <= evt_cnt + EVT_W'(1);
      end
      if (fire_pr && dly_en) begin
        pend <= 1'b1;
        dcnt <= dly_cycles;
      end else if (fire_dly) begin
        pend <= 1'b0;
      end else if (pend && dcnt > DLY_W'(1)) begin
        dcnt <= dcnt - DLY_W'(1);
      end
    end
  end

  logic [N_FE-1:0]            nonempty;
  logic [N_FE-1:0][EVT_W-1:0] head_lsb;
  logic [TYPE_W-1:0]          head_type;

  assign evb_ready = &nonempty;
  assign busy_or   = |fe_busy;
  wire   do_pop    = evb_pop && evb_ready;

  for (genvar i = 0; i < N_FE; i++) begin : g_fe
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic [EVT_W-1:0] mem [DEPTH];
    wire wr = bus_strobe && !fe_drop[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (wr)     wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
        if (do_pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
        cnt <= cnt + CW'(wr) - CW'(do_pop);
      end
    end

    always_ff @(posedge clk)
      if (wr) mem[wp] <= bus_evt;

    assign head_lsb[i] = mem[rp];
    assign nonempty[i] = cnt != '0;
    assign fe_busy[i]  = cnt == CW'(DEPTH);

    if (i == 0) begin : g_ty
      logic [TYPE_W-1:0] tmem [DEPTH];
      always_ff @(posedge clk)
        if (wr) tmem[wp] <= bus_type;
      assign head_type = tmem[rp];
    end
  end

  logic          mis_any;
  logic [IW-1:0] mis_idx;
  always_comb begin
    mis_any = 1'b0;
    mis_idx = '0;
    for (int i = N_FE - 1; i > 0; i--) begin
      if (head_lsb[i] != head_lsb[0]) begin
        mis_any = 1'b1;
        mis_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evb_valid <= 1'b0;
      evb_type  <= '0;
      evb_lsb   <= '0;
      sync_err  <= 1'b0;
      err_idx   <= '0;
    end else begin
      evb_valid <= do_pop;
      if (do_pop) begin
        evb_type <= head_type;
        evb_lsb  <= head_lsb[0];
      end
      if (err_clr) begin
        sync_err <= 1'b0;
      end else if (do_pop && mis_any && !sync_err) begin
        sync_err <= 1'b1;
        err_idx  <= mis_idx;
      end
    end
  end
endmodule

// File: rtl/trig_sync_bus_chk.sv
module trig_sync_bus_chk #(
  parameter int N_FE  = 4,
  parameter int EVT_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_strobe,
  input logic [EVT_W-1:0]        bus_evt,
  input logic                    busy_or,
  input logic                    evb_pop,
  input logic                    evb_ready,
  input logic                    evb_valid,
  input logic                    err_clr,
  input logic                    sync_err,
  input logic [$clog2(N_FE)-1:0] err_idx
);
  logic [EVT_W-1:0] exp_evt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) exp_evt <= '0;
    else if (bus_strobe) exp_evt <= bus_evt + EVT_W'(1);

  assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> !bus_strobe);
  assert_no_trig_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> !$past(busy_or));
  assert_evt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> bus_evt == exp_evt);
  assert_valid_after_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evb_valid |-> $past(evb_pop && evb_ready));
  assert_err_from_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> $past(evb_pop && evb_ready));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !err_clr) |=> (sync_err && $stable(err_idx)));
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !sync_err);
endmodule

bind trig_sync_bus trig_sync_bus_chk #(.N_FE(N_FE), .EVT_W(EVT_W)) u_chk (.*);

// File: tb/tb_trig_sync_bus.sv
module tb_trig_sync_bus;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_req = 0, dly_en = 0, evb_pop = 0, err_clr = 0;
  logic [2:0] trig_type = '0, dly_type = '0;
  logic [5:0] dly_cycles = '0;
  logic [3:0] fe_drop = '0;
  logic bus_strobe, busy_or, evb_ready, evb_valid, sync_err;
  logic [2:0] bus_type, evb_type;
  logic [3:0] bus_evt, fe_busy, evb_lsb;
  logic [1:0] err_idx;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_sync_bus dut (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 5000);
      finish_run();
    end
  end

  typedef struct packed {
    logic req; logic [2:0] ty; logic pop;
    logic s; logic [2:0] sty; logic [3:0] sevt; logic busy;
    logic v; logic [3:0] vl; logic [2:0] vty;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1,3'd5,1'b0, 1'b1,3'd5,4'd0,1'b0, 1'b0,4'd0,3'd0},
    '{1'b1,3'd2,1'b0, 1'b0,3'd0,4'd0,1'b0, 1'b0,4'd0,3'd0},
    '{1'b1,3'd2,1'b0, 1'b1,3'd2,4'd1,1'b0, 1'b0,4'd0,3'd0},
    '{1'b1,3'd2,1'b0, 1'b0,3'd0,4'd0,1'b1, 1'b0,4'd0,3'd0},
    '{1'b1,3'd2,1'b0, 1'b0,3'd0,4'd0,1'b1, 1'b0,4'd0,3'd0},
    '{1'b1,3'd2,1'b1, 1'b0,3'd0,4'd0,1'b0, 1'b1,4'd0,3'd5},
    '{1'b1,3'd7,1'b0, 1'b1,3'd7,4'd2,1'b0, 1'b0,4'd0,3'd0},
    '{1'b0,3'd0,1'b1, 1'b0,3'd0,4'd0,1'b0, 1'b1,4'd1,3'd2},
    '{1'b0,3'd0,1'b1, 1'b0,3'd0,4'd0,1'b0, 1'b1,4'd2,3'd7},
    '{1'b0,3'd0,1'b1, 1'b0,3'd0,4'd0,1'b0, 1'b0,4'd0,3'd0}
  };

  initial begin
    #20; tick;
    check("R1 reset strobe", bus_strobe, 0);
    check("R3 reset busy", busy_or, 0);
    check("R7 reset ready", evb_ready, 0);
    check("R10 reset err", sync_err, 0);
    rst_n = 1; tick;

    // R1 R3 R4 R7 R8: vector walk
    foreach (VEC[k]) begin
      trig_req = VEC[k].req; trig_type = VEC[k].ty; evb_pop = VEC[k].pop;
      tick;
      check($sformatf("R1/R3/R4 v%0d strobe", k), bus_strobe, VEC[k].s);
      if (VEC[k].s) begin
        check($sformatf("R1 v%0d type", k), bus_type, VEC[k].sty);
        check($sformatf("R2 v%0d evt", k), bus_evt, VEC[k].sevt);
      end
      check($sformatf("R3 v%0d busy", k), busy_or, VEC[k].busy);
      check($sformatf("R7/R8 v%0d valid", k), evb_valid, VEC[k].v);
      if (VEC[k].v) begin
        check($sformatf("R8 v%0d lsb", k), evb_lsb, VEC[k].vl);
        check($sformatf("R8 v%0d type", k), evb_type, VEC[k].vty);
      end
    end
    trig_req = 0; evb_pop = 0;

    // R5: delayed trigger, 5 cycles, prompt requests ignored while pending
    dly_en = 1; dly_cycles = 6'd5; dly_type = 3'd6; trig_req = 1; trig_type = 3'd1;
    tick;
    check("R5 prompt strobe", bus_strobe, 1);
    check("R5 prompt evt", bus_evt, 3);
    begin
      int seen = 0;
      for (int k = 1; k < 5; k++) begin tick; seen += bus_strobe; end
      check("R5 quiet while pending", seen, 0);
    end
    tick;
    check("R5 delayed strobe", bus_strobe, 1);
    check("R5 delayed type", bus_type, 6);
    check("R5 delayed evt", bus_evt, 4);
    trig_req = 0; dly_en = 0; evb_pop = 1;
    tick; check("R8 pop prompt lsb", evb_lsb, 3);
    tick; check("R8 pop delayed type", evb_type, 6);
    evb_pop = 0;

    // R6: delayed trigger held by busy
    trig_req = 1; trig_type = 3'd3; tick; trig_req = 0; tick;
    dly_en = 1; dly_cycles = 6'd2; dly_type = 3'd4; trig_req = 1; trig_type = 3'd2;
    tick; trig_req = 0; dly_en = 0;
    tick; tick; tick; tick;
    check("R6 still busy", busy_or, 1);
    check("R6 delayed held", bus_strobe, 0);
    evb_pop = 1; tick; evb_pop = 0;
    check("R6 no strobe on pop edge", bus_strobe, 0);
    tick;
    check("R6 delayed after busy", bus_strobe, 1);
    check("R6 delayed type", bus_type, 4);
    check("R6 delayed evt", bus_evt, 7);
    tick; evb_pop = 1; tick; tick; evb_pop = 0;
    check("R7 drained", evb_ready, 0);

    // R9 R10: mismatch detection
    trig_req = 1; tick; trig_req = 0; fe_drop = 4'b0100; tick; fe_drop = 0;
    trig_req = 1; tick; trig_req = 0; fe_drop = 4'b0010; tick; fe_drop = 0;
    evb_pop = 1; tick; evb_pop = 0;
    check("R9 err set", sync_err, 1);
    check("R9 err idx", err_idx, 2);
    check("R8 lsb board0", evb_lsb, 8);
    trig_req = 1; tick; trig_req = 0; tick;
    evb_pop = 1; tick; evb_pop = 0;
    check("R10 sticky err", sync_err, 1);
    check("R10 sticky idx", err_idx, 2);
    err_clr = 1; tick; err_clr = 0;
    check("R10 cleared", sync_err, 0);
    trig_req = 1; tick; trig_req = 0; tick;
    evb_pop = 1; tick; evb_pop = 0;
    check("R9 new idx", err_idx, 1);
    check("R9 new err", sync_err, 1);

    // R2: counter wrap after reset
    rst_n = 0; tick; rst_n = 1; tick;
    begin
      int n = 0, bad = 0;
      trig_req = 1; evb_pop = 1;
      for (int k = 0; k < 60 && n < 20; k++) begin
        tick;
        if (bus_strobe) begin
          if (bus_evt != 4'(n)) bad++;
          n++;
        end
      end
      trig_req = 0; evb_pop = 0;
      check("R2 wrap sequence", bad, 0);
      check("R2 strobe count", n, 20);
    end
    finish_run();
  end
endmodule